// File: doc/BRIEF.md
# Endpoint Buffer Ownership Pool

This block tracks a pool of equal-sized packet buffers that are shared by several endpoints. At any time each buffer belongs to one of two sides. The packet side fills buffers. The transfer side drains them. A buffer changes sides when its index is handed over, and its data is never copied. Each endpoint owns a fixed ring of one to four buffers, set by a two-bit depth code. Buffers are handed across in ring order.

The packet side reads the index of its current free buffer for an endpoint. When that buffer is full, it commits it together with a byte count. The transfer side reads the index and byte count of the oldest committed buffer for an endpoint. When it has drained that buffer, it releases it. Each endpoint shows a full flag and an empty flag. A new depth configuration is checked against the pool size. A configuration that asks for too many buffers is refused and an error flag is raised.

Top module: `ep_buffer_pool`

## Requirements
- R1: After reset every endpoint uses depth code 0 (one buffer), every buffer is on the packet side (`buf_to_io` all 0), every endpoint shows `ep_empty`=1 and `ep_full`=0, and `cfg_err`=0.
- R2: Depth codes are 2 bits per endpoint, with endpoint e at bits [2e+1:2e]. Code c means c+1 buffers. A `cfg_load` whose total is at most 8 takes effect at the next clock edge. That edge clears `cfg_err`, empties every ring and returns every buffer to the packet side. In the same cycle it takes priority over any commit or release.
- R3: A `cfg_load` whose total is above 8 sets `cfg_err`=1. The active depths, the ring positions, the ownership and the flags all stay as they were.
- R4: Endpoint e owns the buffer indices base(e) up to base(e)+depth(e)-1, where base(e) is the sum of the depths of endpoints 0 to e-1. `pkt_buf` shows base(pkt_ep) plus that endpoint's producer position. `io_buf` shows base(io_ep) plus its consumer position.
- R5: A commit accepted on `pkt_ep` moves `pkt_buf` to the transfer side (its `buf_to_io` bit becomes 1) and stores its byte count. The producer position then steps forward and wraps to 0 after depth-1.
- R6: A release accepted on `io_ep` returns the oldest committed buffer of that endpoint to the packet side. Buffers come back in the order they were committed.
- R7: The stored byte count is `pkt_count` limited to 512. It may be 0. `io_cnt` shows the stored count of `io_buf`.
- R8: `ep_full` is 1 exactly when the endpoint has no buffer left on the packet side. `ep_empty` is 1 exactly when it has no committed buffer.
- R9: A commit to a full endpoint, or a release from an empty one, changes nothing.
- R10: A commit and a release on the same endpoint in the same cycle are both applied when each is allowed, so the number of held buffers stays the same.
- R11: A commit on one endpoint and a release on another endpoint in the same cycle act independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_load | input | 1 | Strobe to apply `cfg_depth` |
| cfg_depth | input | 8 | Depth code per endpoint, 2 bits each |
| cfg_err | output | 1 | Last load was refused |
| pkt_commit | input | 1 | Packet side commits its current buffer |
| pkt_ep | input | 2 | Endpoint selected on the packet side |
| pkt_count | input | 10 | Byte count of the committed buffer |
| pkt_buf | output | 3 | Current free buffer index of `pkt_ep` |
| io_release | input | 1 | Transfer side releases its current buffer |
| io_ep | input | 2 | Endpoint selected on the transfer side |
| io_buf | output | 3 | Oldest committed buffer index of `io_ep` |
| io_cnt | output | 10 | Stored byte count of `io_buf` |
| ep_full | output | 4 | Per-endpoint full flag |
| ep_empty | output | 4 | Per-endpoint empty flag |
| buf_to_io | output | 8 | Per-buffer owner, 1 means transfer side |

## Verification
Suppose a ring position drifts, or an ownership bit is lost. In the same cycle `pkt_buf` or `io_buf` then points at a buffer whose `buf_to_io` bit disagrees with the endpoint's flags. One cycle later, a commit or release that should have been accepted leaves the flags unchanged. A wrong occupancy count shows as `ep_full` or `ep_empty` asserted one cycle early or late when a ring of depth 1 to 4 is filled to its limit. A byte count stored in the wrong slot shows up only on `io_cnt`, once that buffer reaches the head of the ring. For that reason each count is read back in release order.

// File: rtl/epool_pkg.sv
`timescale 1ns/1ps
package epool_pkg;

  typedef enum logic {SIDE_PKT = 1'b0, SIDE_IO = 1'b1} side_e;

  // number of buffers selected by a depth code
  function automatic int unsigned ring_len(int unsigned code);
    return code + 1;
  endfunction

  // next ring position, wrapping after len-1
  function automatic int unsigned ring_next(int unsigned pos, int unsigned len);
    return (pos + 1 >= len) ? 0 : pos + 1;
  endfunction

  // byte count limited to the buffer size
  function automatic int unsigned clamp_bytes(int unsigned n, int unsigned lim);
    return (n > lim) ? lim : n;
  endfunction

endpackage

// File: rtl/epool_cfg.sv
`timescale 1ns/1ps
module epool_cfg
  import epool_pkg::*;
#(
  parameter int NUM_EP  = 4,
  parameter int NUM_BUF = 8,
  parameter int CODE_W  = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_load,
  input  logic [NUM_EP*CODE_W-1:0]   cfg_codes,
  output logic [NUM_EP*CODE_W-1:0]   act_codes,
  output logic                       cfg_err,
  output logic                       cfg_apply
);

  int unsigned req_total;
  logic        fits;

  always_comb begin
    req_total = 0;
    for (int e = 0; e < NUM_EP; e++)
      req_total += ring_len(int'(cfg_codes[e*CODE_W +: CODE_W]));
  end

  assign fits      = (req_total <= NUM_BUF);
  assign cfg_apply = cfg_load && fits;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_codes <= '0;
      cfg_err   <= 1'b0;
    end else if (cfg_load) begin
      if (fits) begin
        act_codes <= cfg_codes;
        cfg_err   <= 1'b0;
      end else begin
        cfg_err   <= 1'b1;
      end
    end
  end

  // R3
  reject_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_load && !fits) |=> ($stable(act_codes) && cfg_err));

  // R2
  accept_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_apply |=> (!cfg_err && act_codes == $past(cfg_codes)));

endmodule

// File: rtl/epool_ring.sv
`timescale 1ns/1ps
module epool_ring
  import epool_pkg::*;
#(
  parameter int MAX_DEPTH = 4,
  parameter int PTR_W     = $clog2(MAX_DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic [PTR_W-1:0] len_code,
  input  logic             commit_req,
  input  logic             release_req,
  output logic [PTR_W-1:0] prod_ptr,
  output logic [PTR_W-1:0] cons_ptr,
  output logic             full,
  output logic             empty,
  output logic             commit_ok,
  output logic             release_ok
);

  localparam int OCC_W = PTR_W + 1;

  logic [OCC_W-1:0] occ_q;
  logic [OCC_W-1:0] len;

  assign len        = OCC_W'(ring_len(int'(len_code)));
  assign full       = (occ_q == len);
  assign empty      = (occ_q == '0);
  assign commit_ok  = commit_req  && !full;
  assign release_ok = release_req && !empty;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      prod_ptr <= '0;
      cons_ptr <= '0;
      occ_q    <= '0;
    end else begin
      if (commit_ok)
        prod_ptr <= PTR_W'(ring_next(int'(prod_ptr), int'(len)));
      if (release_ok)
        cons_ptr <= PTR_W'(ring_next(int'(cons_ptr), int'(len)));
      if (commit_ok && !release_ok)
        occ_q <= occ_q + 1'b1;
      else if (release_ok && !commit_ok)
        occ_q <= occ_q - 1'b1;
    end
  end

  // R8
  occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    occ_q <= len);

  // R9
  full_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && commit_req && !release_req && !clear) |=> ($stable(prod_ptr) && full));

  // R9
  empty_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && release_req && !commit_req && !clear) |=> ($stable(cons_ptr) && empty));

endmodule

// File: rtl/epool_owner.sv
`timescale 1ns/1ps
module epool_owner
  import epool_pkg::*;
#(
  parameter int NUM_BUF = 8,
  parameter int BUF_W   = $clog2(NUM_BUF),
  parameter int CNT_W   = 10
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clear,
  input  logic                     commit_vld,
  input  logic [BUF_W-1:0]         commit_idx,
  input  logic [CNT_W-1:0]         commit_cnt,
  input  logic                     release_vld,
  input  logic [BUF_W-1:0]         release_idx,
  output logic [NUM_BUF-1:0]       to_io,
  output logic [NUM_BUF*CNT_W-1:0] cnt_flat
);

  for (genvar b = 0; b < NUM_BUF; b++) begin : g_buf
    side_e            side_q;
    logic [CNT_W-1:0] cnt_q;
    logic             hit_c;
    logic             hit_r;

    assign hit_c = commit_vld  && (commit_idx  == BUF_W'(b));
    assign hit_r = release_vld && (release_idx == BUF_W'(b));

    always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
        side_q <= SIDE_PKT;
        cnt_q  <= '0;
      end else if (hit_c) begin
        side_q <= SIDE_IO;
        cnt_q  <= commit_cnt;
      end else if (hit_r) begin
        side_q <= SIDE_PKT;
      end
    end

    assign to_io[b]                   = (side_q == SIDE_IO);
    assign cnt_flat[b*CNT_W +: CNT_W] = cnt_q;
  end

  // R5
  commit_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_vld && !clear) |-> !to_io[commit_idx]);

  // R6
  release_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (release_vld && !clear) |-> to_io[release_idx]);

  // R10
  distinct_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_vld && release_vld) |-> (commit_idx != release_idx));

  // R5
  commit_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_vld && !clear) |=> to_io[$past(commit_idx)]);

endmodule

// File: rtl/ep_buffer_pool.sv
`timescale 1ns/1ps
module ep_buffer_pool
  import epool_pkg::*;
#(
  parameter int NUM_EP    = 4,
  parameter int NUM_BUF   = 8,
  parameter int MAX_DEPTH = 4,
  parameter int BUF_BYTES = 512,
  localparam int EP_W     = $clog2(NUM_EP),
  localparam int BUF_W    = $clog2(NUM_BUF),
  localparam int CODE_W   = $clog2(MAX_DEPTH),
  localparam int CNT_W    = $clog2(BUF_BYTES + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_load,
  input  logic [NUM_EP*CODE_W-1:0] cfg_depth,
  output logic                     cfg_err,
  input  logic                     pkt_commit,
  input  logic [EP_W-1:0]          pkt_ep,
  input  logic [CNT_W-1:0]         pkt_count,
  output logic [BUF_W-1:0]         pkt_buf,
  input  logic                     io_release,
  input  logic [EP_W-1:0]          io_ep,
  output logic [BUF_W-1:0]         io_buf,
  output logic [CNT_W-1:0]         io_cnt,
  output logic [NUM_EP-1:0]        ep_full,
  output logic [NUM_EP-1:0]        ep_empty,
  output logic [NUM_BUF-1:0]       buf_to_io
);

  logic [NUM_EP*CODE_W-1:0] act_codes;
  logic                     cfg_apply;
  logic [BUF_W-1:0]         ep_base [NUM_EP];
  logic [CODE_W-1:0]        prod_ptr [NUM_EP];
  logic [CODE_W-1:0]        cons_ptr [NUM_EP];
  logic [NUM_EP-1:0]        commit_ok;
  logic [NUM_EP-1:0]        release_ok;
  logic                     commit_fire;
  logic                     release_fire;
  logic [CNT_W-1:0]         commit_cnt;
  logic [NUM_BUF*CNT_W-1:0] cnt_flat;

  epool_cfg #(.NUM_EP(NUM_EP), .NUM_BUF(NUM_BUF), .CODE_W(CODE_W)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_load  (cfg_load),
    .cfg_codes (cfg_depth),
    .act_codes (act_codes),
    .cfg_err   (cfg_err),
    .cfg_apply (cfg_apply)
  );

  // contiguous allocation: each endpoint starts after all earlier ones
  always_comb begin
    int unsigned acc;
    acc = 0;
    for (int e = 0; e < NUM_EP; e++) begin
      ep_base[e] = BUF_W'(acc);
      acc += ring_len(int'(act_codes[e*CODE_W +: CODE_W]));
    end
  end

  for (genvar e = 0; e < NUM_EP; e++) begin : g_ep
    epool_ring #(.MAX_DEPTH(MAX_DEPTH), .PTR_W(CODE_W)) u_ring (
      .clk         (clk),
      .rst_n       (rst_n),
      .clear       (cfg_apply),
      .len_code    (act_codes[e*CODE_W +: CODE_W]),
      .commit_req  (pkt_commit && (pkt_ep == EP_W'(e))),
      .release_req (io_release && (io_ep == EP_W'(e))),
      .prod_ptr    (prod_ptr[e]),
      .cons_ptr    (cons_ptr[e]),
      .full        (ep_full[e]),
      .empty       (ep_empty[e]),
      .commit_ok   (commit_ok[e]),
      .release_ok  (release_ok[e])
    );
  end

  assign pkt_buf      = ep_base[pkt_ep] + BUF_W'(prod_ptr[pkt_ep]);
  assign io_buf       = ep_base[io_ep]  + BUF_W'(cons_ptr[io_ep]);
  assign commit_fire  = |commit_ok;
  assign release_fire = |release_ok;
  assign commit_cnt   = CNT_W'(clamp_bytes(int'(pkt_count), BUF_BYTES));

  epool_owner #(.NUM_BUF(NUM_BUF), .BUF_W(BUF_W), .CNT_W(CNT_W)) u_owner (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear       (cfg_apply),
    .commit_vld  (commit_fire),
    .commit_idx  (pkt_buf),
    .commit_cnt  (commit_cnt),
    .release_vld (release_fire),
    .release_idx (io_buf),
    .to_io       (buf_to_io),
    .cnt_flat    (cnt_flat)
  );

  assign io_cnt = cnt_flat[io_buf*CNT_W +: CNT_W];

  // R6
  io_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ep_empty[io_ep] |-> buf_to_io[io_buf]);

  // R8
  pkt_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ep_full[pkt_ep] |-> !buf_to_io[pkt_buf]);

  // R7
  cnt_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    io_cnt <= CNT_W'(BUF_BYTES));

  // R2
  load_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_apply |=> (buf_to_io == '0 && ep_empty == '1));

endmodule

// File: tb/ep_buffer_pool_tb_top.sv
`timescale 1ns/1ps
module ep_buffer_pool_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_load;
  logic [7:0] cfg_depth;
  logic       cfg_err;
  logic       pkt_commit;
  logic [1:0] pkt_ep;
  logic [9:0] pkt_count;
  logic [2:0] pkt_buf;
  logic       io_release;
  logic [1:0] io_ep;
  logic [2:0] io_buf;
  logic [9:0] io_cnt;
  logic [3:0] ep_full;
  logic [3:0] ep_empty;
  logic [7:0] buf_to_io;

  int n_chk  = 0;
  int n_fail = 0;

  // model state built from the requirements
  int m_code [4];
  int m_occ  [4];
  int m_prod [4];
  int m_cons [4];
  int m_cnt  [8];
  bit m_io   [8];
  bit m_err;

  always #5 clk = ~clk;

  ep_buffer_pool dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_depth(cfg_depth),
    .cfg_err(cfg_err), .pkt_commit(pkt_commit), .pkt_ep(pkt_ep),
    .pkt_count(pkt_count), .pkt_buf(pkt_buf), .io_release(io_release),
    .io_ep(io_ep), .io_buf(io_buf), .io_cnt(io_cnt), .ep_full(ep_full),
    .ep_empty(ep_empty), .buf_to_io(buf_to_io)
  );

  function automatic int m_len(int e);
    return m_code[e] + 1;
  endfunction

  function automatic int m_base(int e);
    int s = 0;
    for (int i = 0; i < e; i++) s += m_len(i);
    return s;
  endfunction

  task automatic chk(string rq, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  task automatic m_clear();
    for (int e = 0; e < 4; e++) begin
      m_occ[e] = 0; m_prod[e] = 0; m_cons[e] = 0;
    end
    for (int b = 0; b < 8; b++) begin
      m_cnt[b] = 0; m_io[b] = 0;
    end
  endtask

  function automatic bit m_try_cfg(logic [7:0] codes);
    int s = 0;
    for (int e = 0; e < 4; e++) s += int'(codes[2*e +: 2]) + 1;
    return s <= 8;
  endfunction

  task automatic m_apply_cfg(logic [7:0] codes);
    if (m_try_cfg(codes)) begin
      for (int e = 0; e < 4; e++) m_code[e] = int'(codes[2*e +: 2]);
      m_clear();
      m_err = 0;
    end else begin
      m_err = 1;
    end
  endtask

  // compare every flag, owner bit and head pointer with the model
  task automatic check_state(string rq);
    chk(rq, "cfg_err", int'(cfg_err), int'(m_err));
    for (int b = 0; b < 8; b++)
      chk(rq, $sformatf("buf_to_io[%0d]", b), int'(buf_to_io[b]), int'(m_io[b]));
    for (int e = 0; e < 4; e++) begin
      chk(rq, $sformatf("ep_full[%0d]", e), int'(ep_full[e]), int'(m_occ[e] == m_len(e)));
      chk(rq, $sformatf("ep_empty[%0d]", e), int'(ep_empty[e]), int'(m_occ[e] == 0));
      pkt_ep = 2'(e);
      io_ep  = 2'(e);
      #0.5;
      chk(rq, $sformatf("pkt_buf ep%0d", e), int'(pkt_buf), m_base(e) + m_prod[e]);
      chk(rq, $sformatf("io_buf ep%0d", e), int'(io_buf), m_base(e) + m_cons[e]);
      if (m_occ[e] > 0)
        chk(rq, $sformatf("io_cnt ep%0d", e), int'(io_cnt), m_cnt[m_base(e) + m_cons[e]]);
    end
  endtask

  // one cycle with optional commit and release; inputs driven after negedge
  task automatic op(bit c, int ce, int cc, bit r, int re);
    int ci, ri;
    bit cok, rok;
    pkt_commit = c;  pkt_ep = 2'(ce); pkt_count = 10'(cc);
    io_release = r;  io_ep  = 2'(re);
    @(posedge clk);
    cok = c && (m_occ[ce] < m_len(ce));
    rok = r && (m_occ[re] > 0);
    ci  = m_base(ce) + m_prod[ce];
    ri  = m_base(re) + m_cons[re];
    if (cok) begin
      m_io[ci] = 1;
      m_cnt[ci] = (cc > 512) ? 512 : cc;
      m_prod[ce] = (m_prod[ce] + 1 >= m_len(ce)) ? 0 : m_prod[ce] + 1;
      m_occ[ce]++;
    end
    if (rok) begin
      m_io[ri] = 0;
      m_cons[re] = (m_cons[re] + 1 >= m_len(re)) ? 0 : m_cons[re] + 1;
      m_occ[re]--;
    end
    @(negedge clk);
    pkt_commit = 0;
    io_release = 0;
  endtask

  task automatic load_cfg(logic [7:0] codes, bit also_commit);
    cfg_load = 1; cfg_depth = codes;
    pkt_commit = also_commit; pkt_ep = 2'd0; pkt_count = 10'd9;
    @(posedge clk);
    m_apply_cfg(codes);
    @(negedge clk);
    cfg_load = 0; pkt_commit = 0;
  endtask

  task automatic t_reset();
    check_state("R1");
  endtask

  task automatic t_single();
    op(1, 0, 100, 0, 0); check_state("R5");
    chk("R8", "ep_full[0] single", int'(ep_full[0]), 1);
    op(1, 0, 50, 0, 0);  check_state("R9");
    io_ep = 2'd0; #0.5;
    chk("R9", "io_cnt kept", int'(io_cnt), 100);
    op(0, 0, 0, 1, 0);   check_state("R6");
    op(0, 0, 0, 1, 0);   check_state("R9");
  endtask

  task automatic t_cfg_accept();
    load_cfg({2'd0, 2'd0, 2'd1, 2'd3}, 0);
    check_state("R2");
    pkt_ep = 2'd1; #0.5; chk("R4", "base ep1", int'(pkt_buf), 4);
    pkt_ep = 2'd2; #0.5; chk("R4", "base ep2", int'(pkt_buf), 6);
    pkt_ep = 2'd3; #0.5; chk("R4", "base ep3", int'(pkt_buf), 7);
  endtask

  task automatic t_ring();
    int cnts [4] = '{10, 0, 512, 700};
    int want [4] = '{10, 0, 512, 512};
    for (int i = 0; i < 4; i++) begin
      op(1, 0, cnts[i], 0, 0); check_state("R5");
    end
    chk("R8", "ep_full[0] quad", int'(ep_full[0]), 1);
    for (int i = 0; i < 4; i++) begin
      io_ep = 2'd0; #0.5;
      chk("R7", $sformatf("io_cnt order %0d", i), int'(io_cnt), want[i]);
      chk("R6", $sformatf("io_buf order %0d", i), int'(io_buf), i);
      op(0, 0, 0, 1, 0); check_state("R6");
    end
    op(1, 0, 3, 0, 0); check_state("R4");
  endtask

  task automatic t_simul();
    op(1, 1, 33, 0, 0); check_state("R5");
    op(1, 1, 44, 1, 1); check_state("R10");
    io_ep = 2'd1; #0.5;
    chk("R10", "io_cnt ep1", int'(io_cnt), 44);
    chk("R10", "ep_empty[1]", int'(ep_empty[1]), 0);
  endtask

  task automatic t_cross();
    op(1, 2, 7, 1, 0); check_state("R11");
    op(1, 3, 8, 1, 1); check_state("R11");
  endtask

  task automatic t_reject();
    load_cfg(8'hFF, 0);
    check_state("R3");
    chk("R3", "cfg_err set", int'(cfg_err), 1);
    load_cfg(8'h00, 0);
    check_state("R2");
    op(1, 0, 5, 0, 0);
    load_cfg({2'd1, 2'd1, 2'd1, 2'd1}, 1);
    check_state("R2");
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL R1 watchdog expired: actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 0; cfg_load = 0; cfg_depth = '0; pkt_commit = 0; pkt_ep = '0;
    pkt_count = '0; io_release = 0; io_ep = '0;
    for (int e = 0; e < 4; e++) m_code[e] = 0;
    m_err = 0;
    m_clear();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_single();
    t_cfg_accept();
    t_ring();
    t_simul();
    t_cross();
    t_reject();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule